// File: doc/BRIEF.md
# Edge Boundary Mask Generator

This block works out which elements of an 8-byte memory block a partial store may write when a span of pixels is filled from a start address to an end address. It looks at where each address lies inside its 8-byte block and turns that position into a left-edge mask and a right-edge mask. The masks have one bit per element, and an element is 8, 16 or 32 bits wide. When both addresses fall in the same block, the result is the overlap of the two masks. Otherwise the left mask is used alone, because the span runs on into later blocks.

A 4-bit mode picks the element size, the byte ordering and whether integer condition flags are produced. When flags are requested, the block also returns negative, zero, overflow and carry flags for start minus end, in both a 32-bit view and a 64-bit view, and raises a write enable. A 32-bit address mode makes the mask logic use only the low 32 bits of each address. Each request is accepted with a valid strobe, and its result is registered one clock later.

Top module: `edge_mask_gen`

## Requirements
- R1: `out_valid` goes high exactly one cycle after each cycle in which `in_valid` is high, and is low otherwise. After reset, `out_valid`, `edge_mask`, `cc_we`, `icc` and `xcc` are all zero.
- R2: Size code 0 (mode[1:0]=0) gives 8-bit elements, and size code 3 behaves the same way. With mode[2]=0 (big-endian), the left mask is 0xFF shifted right by start[2:0], and the right mask has its top end[2:0]+1 bits set (0x80 for offset 0, 0xFF for offset 7).
- R3: For 8-bit elements with mode[2]=1 (little-endian), the left mask is 0xFF shifted left by start[2:0] and kept to 8 bits, and the right mask has its low end[2:0]+1 bits set.
- R4: Size code 1 gives 16-bit elements, indexed by address bits [2:1]. Big-endian: left is F,7,3,1 and right is 8,C,E,F. Little-endian: left is F,E,C,8 and right is 1,3,7,F.
- R5: Size code 2 gives 32-bit elements, indexed by address bit 2. Big-endian: left is 3,1 and right is 2,3. Little-endian: left is 3,2 and right is 1,3.
- R6: If start and end are equal in every bit above bit 2, the result is left AND right. Otherwise it is the left mask alone, whichever of the two addresses is larger.
- R7: When `addr32` is 1, only bits [31:0] of each address feed the block comparison and the mask offsets.
- R8: With mode[3]=0, `cc_we` goes high together with `out_valid`. `xcc` and `icc` then take the flags {N,Z,V,C} (bit 3 down to bit 0) of the 64-bit and 32-bit subtraction start minus end. The flags always use the full, unmasked addresses. C is the unsigned borrow and V is the signed overflow.
- R9: With mode[3]=1, `cc_we` stays low and `icc` and `xcc` keep their previous values.
- R10: `edge_mask` is the 8-, 4- or 2-bit element mask with zeros in all higher bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 4 | [1:0] element size, [2] little-endian, [3] suppress flags |
| addr32 | input | 1 | Use only the low 32 address bits for the mask |
| start_addr | input | 64 | Span start address |
| end_addr | input | 64 | Span end address |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| edge_mask | output | 64 | Zero-extended element mask |
| cc_we | output | 1 | Flag write enable |
| icc | output | 4 | 32-bit view flags {N,Z,V,C} |
| xcc | output | 4 | 64-bit view flags {N,Z,V,C} |

## Verification
The bench covers every mode with all 64 pairs of start and end offsets inside one block. This exposes a table swapped between byte orders, a mask indexed by the wrong address bits, or an off-by-one right edge (0x00 instead of 0x80). Spans that cross blocks in both directions catch a design that ANDs the two masks without checking the block. A 32-bit mode case with different upper halves but equal low halves catches a design that masks the flag inputs too, or that fails to mask the block compare. Flag cases with signed overflow, unsigned borrow and a 32-bit-only zero result separate the V, C and Z logic. A flag-suppressed request placed after a flag-writing one shows whether the flag registers wrongly change.

// File: rtl/edge_pkg.sv
// Package: shared types for the edge boundary mask generator.
// Assumes an 8-byte memory block; element size codes are fixed by the mode field.
package edge_pkg;
    localparam int BLK_BYTES = 8;
    localparam int BLK_LSB   = $clog2(BLK_BYTES);

    // Element size code carried in mode[1:0]; the reserved code acts as bytes.
    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_RSV = 2'd3
    } elem_sz_e;

    // Integer flags of a subtraction, packed {n,z,v,c} from MSB to LSB.
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;
endpackage

// File: rtl/edge_lane_mask.sv
// Module: edge_lane_mask
// Builds the left and right edge masks for one element width.
// Assumes 8-byte blocks; LANE_BYTES must be 1, 2 or 4. Bits above the lane
// count are driven to zero.
module edge_lane_mask #(
    parameter int LANE_BYTES = 1
) (
    input  logic [2:0] start_off_i,
    input  logic [2:0] end_off_i,
    input  logic       little_i,
    output logic [7:0] left_o,
    output logic [7:0] right_o
);
    localparam int LANES = edge_pkg::BLK_BYTES / LANE_BYTES;
    localparam int SH    = $clog2(LANE_BYTES);

    logic [2:0] s_idx;
    logic [2:0] e_idx;

    // Element index of each address inside its block.
    assign s_idx = start_off_i >> SH;
    assign e_idx = end_off_i >> SH;

    // Each mask bit compares its element position with the edge index; the
    // position counts from the MSB for big-endian and from the LSB otherwise.
    for (genvar k = 0; k < 8; k++) begin : g_bit
        if (k < LANES) begin : g_live
            localparam logic [2:0] POS_BE = 3'(LANES - 1 - k);
            localparam logic [2:0] POS_LE = 3'(k);
            assign left_o[k]  = little_i ? (POS_LE >= s_idx) : (POS_BE >= s_idx);
            assign right_o[k] = little_i ? (POS_LE <= e_idx) : (POS_BE <= e_idx);
        end else begin : g_pad
            assign left_o[k]  = 1'b0;
            assign right_o[k] = 1'b0;
        end
    end
endmodule

// File: rtl/edge_cc_calc.sv
// Module: edge_cc_calc
// Produces the N, Z, V, C flags of a - b on a W-bit view.
// Assumes a two's-complement view for V and an unsigned borrow for C.
module edge_cc_calc #(
    parameter int W = 64
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output edge_pkg::cc_t cc_o
);
    logic [W-1:0] diff;

    // Difference and the flags derived from it.
    always_comb begin
        diff    = a_i - b_i;
        cc_o.n  = diff[W-1];
        cc_o.z  = (diff == '0);
        cc_o.v  = (a_i[W-1] ^ b_i[W-1]) & (diff[W-1] ^ a_i[W-1]);
        cc_o.c  = (a_i < b_i);
    end
endmodule

// File: rtl/edge_mask_gen.sv
// Module: edge_mask_gen (top)
// Turns a start and end address into a partial-store element mask and,
// when asked, into subtraction flags. The result is registered one cycle after in_valid.
// Assumes ADDR_W >= 33 (the flags use a 32-bit and a full-width view) and OUT_W >= 8.
module edge_mask_gen #(
    parameter int ADDR_W = 64,
    parameter int OUT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        mode,
    input  logic              addr32,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              out_valid,
    output logic [OUT_W-1:0]  edge_mask,
    output logic              cc_we,
    output logic [3:0]        icc,
    output logic [3:0]        xcc
);
    import edge_pkg::*;

    localparam int NARROW_W = 32;
    localparam int N_SIZES  = 3;

    elem_sz_e         size_code;
    logic             little;
    logic             no_cc;
    logic [ADDR_W-1:0] s_eff;
    logic [ADDR_W-1:0] e_eff;
    logic             same_blk;
    logic [7:0]       lane_left  [N_SIZES];
    logic [7:0]       lane_right [N_SIZES];
    logic [7:0]       sel_left;
    logic [7:0]       sel_right;
    logic [7:0]       mask_d;
    cc_t              cc32;
    cc_t              cc64;

    // Mode field decode.
    assign size_code = elem_sz_e'(mode[1:0]);
    assign little    = mode[2];
    assign no_cc     = mode[3];

    // Address view seen by the mask logic; flags use the raw inputs.
    assign s_eff = addr32 ? {{(ADDR_W-NARROW_W){1'b0}}, start_addr[NARROW_W-1:0]} : start_addr;
    assign e_eff = addr32 ? {{(ADDR_W-NARROW_W){1'b0}}, end_addr[NARROW_W-1:0]}   : end_addr;

    // Both addresses in the same 8-byte block.
    assign same_blk = (s_eff[ADDR_W-1:BLK_LSB] == e_eff[ADDR_W-1:BLK_LSB]);

    // One mask builder per element width: 1, 2 and 4 bytes.
    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        edge_lane_mask #(
            .LANE_BYTES (1 << g)
        ) u_lane (
            .start_off_i (s_eff[BLK_LSB-1:0]),
            .end_off_i   (e_eff[BLK_LSB-1:0]),
            .little_i    (little),
            .left_o      (lane_left[g]),
            .right_o     (lane_right[g])
        );
    end

    // Pick the builder for the requested element size.
    always_comb begin
        unique case (size_code)
            SZ_B16: begin
                sel_left  = lane_left[1];
                sel_right = lane_right[1];
            end
            SZ_B32: begin
                sel_left  = lane_left[2];
                sel_right = lane_right[2];
            end
            default: begin
                sel_left  = lane_left[0];
                sel_right = lane_right[0];
            end
        endcase
    end

    // Combine the edges only when the span stays inside one block.
    assign mask_d = same_blk ? (sel_left & sel_right) : sel_left;

    // Flag calculation on the narrow and full-width views.
    edge_cc_calc #(.W(NARROW_W)) u_cc32 (
        .a_i  (start_addr[NARROW_W-1:0]),
        .b_i  (end_addr[NARROW_W-1:0]),
        .cc_o (cc32)
    );

    edge_cc_calc #(.W(ADDR_W)) u_cc64 (
        .a_i  (start_addr),
        .b_i  (end_addr),
        .cc_o (cc64)
    );

    // Output registers: valid and write strobes follow each request; the
    // flags are loaded only when they are requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            cc_we     <= 1'b0;
            edge_mask <= '0;
            icc       <= '0;
            xcc       <= '0;
        end else begin
            out_valid <= in_valid;
            cc_we     <= in_valid & ~no_cc;
            if (in_valid) begin
                edge_mask <= {{(OUT_W-8){1'b0}}, mask_d};
            end
            if (in_valid && !no_cc) begin
                icc <= cc32;
                xcc <= cc64;
            end
        end
    end
endmodule

// File: rtl/edge_mask_gen_chk.sv
// Module: edge_mask_gen_chk
// Checks the timing and the flag behaviour of edge_mask_gen through its ports.
// It is attached to every instance of the top module by the bind below.
module edge_mask_gen_chk #(
    parameter int ADDR_W = 64,
    parameter int OUT_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        mode,
    input logic              addr32,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] end_addr,
    input logic              out_valid,
    input logic [OUT_W-1:0]  edge_mask,
    input logic              cc_we,
    input logic [3:0]        icc,
    input logic [3:0]        xcc
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                                   // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                                 // R1
    AST_WORD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1:0] == 2'd2) |=> (edge_mask[OUT_W-1:2] == '0));         // R10
    AST_HALF_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1:0] == 2'd1) |=> (edge_mask[OUT_W-1:4] == '0));         // R10
    AST_CROSS_BLOCK_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[2:0] == 3'd0 && !addr32 &&
         start_addr[ADDR_W-1:3] != end_addr[ADDR_W-1:3])
        |=> (edge_mask[7:0] == (8'hFF >> $past(start_addr[2:0]))));                // R6
    AST_NOCC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[3]) |=> !cc_we);                                         // R9
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_we |-> ($stable(icc) && $stable(xcc)));                                // R9
    AST_WE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |-> out_valid);                                                      // R8
    AST_ZERO_NESTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_we && xcc[2]) |-> icc[2]);                                             // R8
endmodule

bind edge_mask_gen edge_mask_gen_chk #(
    .ADDR_W (ADDR_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode       (mode),
    .addr32     (addr32),
    .start_addr (start_addr),
    .end_addr   (end_addr),
    .out_valid  (out_valid),
    .edge_mask  (edge_mask),
    .cc_we      (cc_we),
    .icc        (icc),
    .xcc        (xcc)
);

// File: tb/edge_mask_gen_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results and the monitor
// compares them when out_valid shows up.
module edge_mask_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic        addr32 = 1'b0;
    logic [63:0] start_addr = '0;
    logic [63:0] end_addr = '0;
    logic        out_valid;
    logic [63:0] edge_mask;
    logic        cc_we;
    logic [3:0]  icc;
    logic [3:0]  xcc;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    typedef struct {
        logic [63:0] mask;
        logic        we;
        logic [3:0]  icc;
        logic [3:0]  xcc;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    logic [3:0] mdl_icc = '0;
    logic [3:0] mdl_xcc = '0;

    edge_mask_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .mode       (mode),
        .addr32     (addr32),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .out_valid  (out_valid),
        .edge_mask  (edge_mask),
        .cc_we      (cc_we),
        .icc        (icc),
        .xcc        (xcc)
    );

    always #2 clk = ~clk;

    // Expected element mask, built from the tables stated in the requirements.
    function automatic logic [7:0] model_mask(input logic [3:0] md, input logic a32,
                                              input logic [63:0] s, input logic [63:0] e);
        logic [63:0] sm, em;
        logic [2:0]  so, eo;
        logic [7:0]  l, r;
        sm = a32 ? {32'h0, s[31:0]} : s;
        em = a32 ? {32'h0, e[31:0]} : e;
        so = sm[2:0];
        eo = em[2:0];
        case (md[1:0])
            2'd1: begin
                if (!md[2]) begin
                    case (so[2:1]) 0: l = 8'hF; 1: l = 8'h7; 2: l = 8'h3; default: l = 8'h1; endcase
                    case (eo[2:1]) 0: r = 8'h8; 1: r = 8'hC; 2: r = 8'hE; default: r = 8'hF; endcase
                end else begin
                    case (so[2:1]) 0: l = 8'hF; 1: l = 8'hE; 2: l = 8'hC; default: l = 8'h8; endcase
                    case (eo[2:1]) 0: r = 8'h1; 1: r = 8'h3; 2: r = 8'h7; default: r = 8'hF; endcase
                end
            end
            2'd2: begin
                if (!md[2]) begin
                    l = so[2] ? 8'h1 : 8'h3;
                    r = eo[2] ? 8'h3 : 8'h2;
                end else begin
                    l = so[2] ? 8'h2 : 8'h3;
                    r = eo[2] ? 8'h3 : 8'h1;
                end
            end
            default: begin
                if (!md[2]) begin
                    l = 8'hFF >> so;
                    r = 8'hFF << (3'd7 - eo);
                end else begin
                    l = 8'hFF << so;
                    r = 8'hFF >> (3'd7 - eo);
                end
            end
        endcase
        return (sm[63:3] == em[63:3]) ? (l & r) : l;
    endfunction

    // Expected {N,Z,V,C} of s - e on the full and the low-32-bit views.
    function automatic logic [3:0] model_cc(input logic [63:0] s, input logic [63:0] e,
                                            input logic wide);
        logic signed [64:0] sd;
        logic [64:0]        ud;
        logic [63:0]        d;
        if (wide) begin
            sd = $signed({s[63], s}) - $signed({e[63], e});
            ud = {1'b0, s} - {1'b0, e};
            d  = sd[63:0];
            return {d[63], d == 64'h0, sd[64] != sd[63], ud[64]};
        end else begin
            sd = $signed({{33{s[31]}}, s[31:0]}) - $signed({{33{e[31]}}, e[31:0]});
            ud = {33'h0, s[31:0]} - {33'h0, e[31:0]};
            return {sd[31], sd[31:0] == 32'h0, sd[32] != sd[31], ud[32]};
        end
    endfunction

    // Driver: present one request and queue what should come back.
    task automatic send(input logic [3:0] md, input logic a32,
                        input logic [63:0] s, input logic [63:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        mode       = md;
        addr32     = a32;
        start_addr = s;
        end_addr   = e;
        in_valid   = 1'b1;
        if (!md[3]) begin
            mdl_icc = model_cc(s, e, 1'b0);
            mdl_xcc = model_cc(s, e, 1'b1);
        end
        it.mask = {56'h0, model_mask(md, a32, s, e)};
        it.we   = !md[3];
        it.icc  = mdl_icc;
        it.xcc  = mdl_xcc;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pop and compare each result when it appears.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1", "unexpected out_valid", 64'd1, 64'd0);
            end else begin
                exp_t it;
                string ftag;
                it = sb_q.pop_front();
                ftag = it.we ? "R8" : "R9";
                check(edge_mask == it.mask, it.tag, "edge_mask", edge_mask, it.mask);
                check(cc_we == it.we, ftag, "cc_we", {63'h0, cc_we}, {63'h0, it.we});
                check(icc == it.icc, ftag, "icc", {60'h0, icc}, {60'h0, it.icc});
                check(xcc == it.xcc, ftag, "xcc", {60'h0, xcc}, {60'h0, it.xcc});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        string t;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", {63'h0, out_valid}, 64'h0);
        check(edge_mask == 64'h0, "R1", "edge_mask in reset", edge_mask, 64'h0);
        check({cc_we, icc, xcc} == 9'h0, "R1", "flags in reset", {55'h0, cc_we, icc, xcc}, 64'h0);
        rst_n = 1'b1;

        // R2..R5, R6, R10: every mode with every offset pair in one block
        for (int md = 0; md < 16; md++) begin
            for (int so = 0; so < 8; so++) begin
                for (int eo = 0; eo < 8; eo++) begin
                    case (md % 4)
                        1: t = "R4";
                        2: t = "R5";
                        default: t = ((md / 4) % 2 == 1) ? "R3" : "R2";
                    endcase
                    send(4'(md), 1'b0, 64'h1000 + 64'(so), 64'h1000 + 64'(eo), t);
                end
            end
        end

        // R6: spans crossing blocks in both directions keep the left mask
        for (int md = 0; md < 8; md++) begin
            send(4'(md), 1'b0, 64'h2005, 64'h2040, "R6");
            send(4'(md), 1'b0, 64'h3043, 64'h3001, "R6");
            send(4'(md), 1'b0, 64'h0000_0100_0000_2002, 64'h2006, "R6");
        end

        // R1: a gap in requests leaves out_valid low
        idle();
        idle();
        check(out_valid == 1'b0, "R1", "out_valid after gap", {63'h0, out_valid}, 64'h0);

        // R7: low halves share a block, upper halves differ
        send(4'd0, 1'b1, 64'hAAAA_0000_0000_1003, 64'h5555_0000_0000_1006, "R7");
        send(4'd0, 1'b0, 64'hAAAA_0000_0000_1003, 64'h5555_0000_0000_1006, "R7");
        send(4'd5, 1'b1, 64'h1234_5678_0000_0012, 64'h8765_4321_0000_0014, "R7");

        // R8: overflow, borrow, equality and a zero only in the 32-bit view
        send(4'd0, 1'b0, 64'h8000_0000_0000_0000, 64'h1, "R8");
        send(4'd0, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        send(4'd4, 1'b0, 64'h10, 64'h10, "R8");
        send(4'd1, 1'b0, 64'h3, 64'h9, "R8");
        send(4'd2, 1'b0, 64'h1_0000_0005, 64'h5, "R8");
        send(4'd0, 1'b0, 64'h0000_0000_8000_0000, 64'h1, "R8");

        // R9: a flag write, then suppressed requests with other operands
        send(4'd0, 1'b0, 64'h20, 64'h7, "R8");
        send(4'd8, 1'b0, 64'h7, 64'h20, "R9");
        send(4'd14, 1'b0, 64'h8000_0000_0000_0000, 64'h1, "R9");
        idle();
        idle();
        check(sb_q.size() == 0, "R1", "queue drained", 64'(sb_q.size()), 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule